// File: doc/BRIEF.md
# Manchester Serial Configuration Receiver

This block accepts configuration words from a host over two wires: a serial clock and a serial data line. Every data bit is carried as a pair of half-bits on two successive rising edges of the serial clock, in Manchester form. The block brings both wires into the system clock domain, decodes each pair, rejects invalid pairs, and gathers 21 decoded bits into one word. A finished, fully valid word produces a single-cycle write strobe with a 3-bit register select and an 18-bit payload, which a neighbouring pair of frequency-synthesizer register sets decodes.

Words can arrive at any time during operation. Each one rewrites only the register set it selects, and no reset is needed between words. A word that is abandoned part way is dropped, either because of a bad pair or because the host stops clocking for longer than `TIMEOUT_CYC` system clocks. The next pair then starts a new word.

The decoder is a three-state machine. `ST_IDLE` means no bit of the current word is held yet. `ST_HALF` means the first half of a bit has been captured. `ST_WAIT` means at least one bit is held and the first half of the next bit is awaited. The transitions are as follows:
- IDLE→HALF on a serial rising edge.
- WAIT→HALF on a serial rising edge.
- HALF→WAIT on a valid pair that is not the last bit.
- HALF→IDLE on a valid last pair (commit).
- HALF→IDLE on an invalid pair (coding error).
- HALF→IDLE and WAIT→IDLE on timeout.

Top module: `mcfg_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `wr_stb`, `wr_addr` and `wr_data` are all zero until the first word commits.
- R2: A half-bit pair of 1 then 0 decodes as data bit 1, and a pair of 0 then 1 decodes as data bit 0.
- R3: The first decoded bit of a word becomes word bit 0, and the 21st becomes word bit 20. Word bits 20:18 appear on `wr_addr` and word bits 17:0 appear on `wr_data`.
- R4: `wr_stb` is high for exactly one system clock per committed word. It is high in the third `clk` cycle after the cycle in which `ser_clk` rises for the second half of the 21st bit, counting from the first rising `clk` edge that sees the new level.
- R5: No strobe is issued before 21 valid bits have been received. `wr_addr` and `wr_data` change only together with a strobe.
- R6: A pair of 0-0 or 1-1 discards the partial word and issues no strobe. The next rising edge of `ser_clk` starts the first half of bit 0 of a new word.
- R7: If more than `TIMEOUT_CYC` system clocks pass with no rising edge of `ser_clk` while a word is partial, the partial word is discarded. A gap shorter than `TIMEOUT_CYC` keeps the word intact.
- R8: Consecutive words are accepted without any reset, and each one produces its own strobe with its own select and payload.
- R9: `ser_dat` is sampled only at rising edges of `ser_clk`, so changes of `ser_dat` while `ser_clk` is steady have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the host, asynchronous to `clk` |
| ser_dat | input | 1 | Serial data from the host, Manchester half-bits |
| wr_stb | output | 1 | One-cycle write strobe for a committed word |
| wr_addr | output | 3 | Register-set select, word bits 20:18 |
| wr_data | output | 18 | Payload, word bits 17:0 |

## Verification
The assertions take several things for granted about the inputs:
- `ser_dat` is settled at least two system clocks before each rising edge of `ser_clk`.
- Each level of `ser_clk` lasts several system clocks, so no edge is lost in the synchronizer.
- A run with no edges is measured from the last rising edge the synchronizer reports.

The stimulus keeps within these bounds. Data is set, and glitched, only while `ser_clk` is low, at least three system clocks before the rise. Each serial level is held for four system clocks. Gaps are chosen either well below or well above `TIMEOUT_CYC`, never near it.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HALF = 2'd1,
        ST_WAIT = 2'd2
    } rx_state_t;

endpackage

// File: rtl/mcfg_sync.sv
module mcfg_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/mcfg_quiet_timer.sv
module mcfg_quiet_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    assign expired = run && !clear && (cnt == LIM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (!run || clear)     cnt <= '0;
        else if (cnt != LIM)        cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/mcfg_decoder.sv
module mcfg_decoder
    import mcfg_pkg::*;
#(
    parameter int WORD_W = 21,
    parameter int ADDR_W = 3,
    localparam int DATA_W = WORD_W - ADDR_W,
    localparam int BW     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              dat,
    input  logic              timeout,
    output rx_state_t         st,
    output logic [BW-1:0]     bit_cnt,
    output logic              half0,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam logic [BW-1:0] LAST = BW'(WORD_W - 1);

    rx_state_t        st_nx;
    logic [WORD_W-1:0] shreg;
    logic             pair_ok;
    logic             is_last;
    logic             commit;
    logic [WORD_W-1:0] word_full;

    assign pair_ok   = (half0 != dat);
    assign is_last   = (bit_cnt == LAST);
    assign commit    = (st == ST_HALF) && rise && pair_ok && is_last;
    assign word_full = {half0, shreg[WORD_W-1:1]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next-state decode
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (rise) st_nx = ST_HALF;
            end
            ST_HALF: begin
                if (rise) begin
                    if (!pair_ok)     st_nx = ST_IDLE;
                    else if (is_last) st_nx = ST_IDLE;
                    else              st_nx = ST_WAIT;
                end else if (timeout) begin
                    st_nx = ST_IDLE;
                end
            end
            ST_WAIT: begin
                if (rise)         st_nx = ST_HALF;
                else if (timeout) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // half-bit capture, shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half0   <= 1'b0;
            shreg   <= '0;
            bit_cnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    bit_cnt <= '0;
                    if (rise) half0 <= dat;
                end
                ST_WAIT: begin
                    if (rise)         half0   <= dat;
                    else if (timeout) bit_cnt <= '0;
                end
                ST_HALF: begin
                    if (rise) begin
                        if (pair_ok && !is_last) begin
                            shreg   <= word_full;
                            bit_cnt <= bit_cnt + BW'(1);
                        end else begin
                            bit_cnt <= '0;
                        end
                    end else if (timeout) begin
                        bit_cnt <= '0;
                    end
                end
                default: bit_cnt <= '0;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= commit;
            if (commit) begin
                wr_addr <= word_full[WORD_W-1:DATA_W];
                wr_data <= word_full[DATA_W-1:0];
            end
        end
    end

endmodule

// File: rtl/mcfg_rx.sv
module mcfg_rx
    import mcfg_pkg::*;
#(
    parameter int WORD_W      = 21,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 64,
    localparam int DATA_W = WORD_W - ADDR_W,
    localparam int BW     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic [1:0]    synced;
    logic          s_clk;
    logic          s_dat;
    logic          s_clk_d;
    logic          ser_rise;
    logic          timeout;
    rx_state_t     st;
    logic [BW-1:0] bit_cnt;
    logic          half0;

    mcfg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({ser_clk, ser_dat}),
        .d_out (synced)
    );

    assign s_clk = synced[1];
    assign s_dat = synced[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_clk_d <= 1'b0;
        else        s_clk_d <= s_clk;
    end

    assign ser_rise = s_clk && !s_clk_d;

    mcfg_quiet_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st != ST_IDLE),
        .clear   (ser_rise),
        .expired (timeout)
    );

    mcfg_decoder #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (ser_rise),
        .dat     (s_dat),
        .timeout (timeout),
        .st      (st),
        .bit_cnt (bit_cnt),
        .half0   (half0),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

endmodule

// File: rtl/mcfg_rx_chk.sv
module mcfg_rx_chk
    import mcfg_pkg::*;
#(
    parameter int WORD_W      = 21,
    parameter int ADDR_W      = 3,
    parameter int TIMEOUT_CYC = 64,
    localparam int DATA_W = WORD_W - ADDR_W,
    localparam int BW     = $clog2(WORD_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input rx_state_t         st,
    input logic [BW-1:0]     bit_cnt,
    input logic              ser_rise,
    input logic              s_dat,
    input logic              half0
);

    localparam int QW = $clog2(TIMEOUT_CYC + 3);
    localparam logic [QW-1:0] QMAX = QW'(TIMEOUT_CYC + 2);
    localparam logic [QW-1:0] QLIM = QW'(TIMEOUT_CYC);

    logic [QW-1:0] quiet;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           quiet <= '0;
        else if (ser_rise)                    quiet <= '0;
        else if (st != ST_IDLE && quiet != QMAX) quiet <= quiet + QW'(1);
    end

    // R4
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> ($stable(wr_addr) && $stable(wr_data)));

    // R3
    full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(bit_cnt) == BW'(WORD_W - 1)));

    // R6
    bad_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALF && ser_rise && s_dat == half0) |=> (st == ST_IDLE && !wr_stb));

    // R7
    quiet_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet > QLIM) |-> (st == ST_IDLE));

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |-> (!wr_stb && wr_addr == '0 && wr_data == '0));

endmodule

bind mcfg_rx mcfg_rx_chk #(
    .WORD_W      (WORD_W),
    .ADDR_W      (ADDR_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .st       (st),
    .bit_cnt  (bit_cnt),
    .ser_rise (ser_rise),
    .s_dat    (s_dat),
    .half0    (half0)
);

// File: tb/mcfg_rx_test.sv
module mcfg_rx_test;

    localparam int TO = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        wr_stb;
    logic [2:0]  wr_addr;
    logic [17:0] wr_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    string req = "R1";

    int          exp_cyc [$];
    logic [20:0] exp_word[$];

    always #2 clk = ~clk;

    mcfg_rx #(.TIMEOUT_CYC(TO)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    always @(posedge clk) cyc = cyc + 1;

    // per-cycle comparison against the expected-strobe queue (R4, R5)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic exp_stb;
            exp_stb = (exp_cyc.size() > 0) && (exp_cyc[0] == cyc);
            checks++;
            if (wr_stb !== exp_stb) begin
                errors++;
                $display("FAIL %s strobe at cycle %0d: got %b expected %b", req, cyc, wr_stb, exp_stb);
            end
            if (exp_stb) begin
                checks++;
                if ({wr_addr, wr_data} !== exp_word[0]) begin
                    errors++;
                    $display("FAIL %s word: got %h expected %h", req, {wr_addr, wr_data}, exp_word[0]);
                end
                void'(exp_cyc.pop_front());
                void'(exp_word.pop_front());
            end
            if (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
                errors++;
                $display("FAIL %s missing strobe: got none expected at %0d", req, exp_cyc[0]);
                void'(exp_cyc.pop_front());
                void'(exp_word.pop_front());
            end
        end
    end

    // one half-bit; data glitched while ser_clk is low (R9)
    task automatic send_half(input logic b, input bit commit, input logic [20:0] w);
        ser_dat = ~b;
        @(negedge clk);
        ser_dat = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        if (commit) begin
            exp_cyc.push_back(cyc + 3);
            exp_word.push_back(w);
        end
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    // bits lo..hi of w, LSB first (R2, R3)
    task automatic send_bits(input logic [20:0] w, input int lo, input int hi, input bit commit);
        for (int i = lo; i <= hi; i++) begin
            send_half(w[i], 1'b0, w);
            send_half(~w[i], commit && (i == 20), w);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (wr_stb !== 1'b0 || wr_addr !== 3'd0 || wr_data !== 18'd0) begin
            errors++;
            $display("FAIL R1 reset: got %b %h %h expected 0 0 0", wr_stb, wr_addr, wr_data);
        end
        rst_n = 1'b1;
        idle(5);
        checks++;
        if (wr_stb !== 1'b0 || wr_addr !== 3'd0 || wr_data !== 18'd0) begin
            errors++;
            $display("FAIL R1 after reset: got %b %h %h expected 0 0 0", wr_stb, wr_addr, wr_data);
        end

        req = "R2/R3";
        send_bits({3'd5, 18'h2A5C3}, 0, 20, 1'b1);
        idle(10);

        req = "R8";
        send_bits({3'd0, 18'h3FFFF}, 0, 20, 1'b1);
        send_bits({3'd7, 18'h00000}, 0, 20, 1'b1);
        send_bits({3'd2, 18'h15555}, 0, 20, 1'b1);
        idle(10);

        req = "R6";
        send_bits({3'd3, 18'h0F0F0}, 0, 19, 1'b0);
        send_half(1'b1, 1'b0, '0);
        send_half(1'b1, 1'b0, '0);
        send_bits({3'd1, 18'h12345}, 0, 20, 1'b1);
        send_half(1'b0, 1'b0, '0);
        send_half(1'b0, 1'b0, '0);
        send_bits({3'd6, 18'h2BCDE}, 0, 20, 1'b1);
        idle(10);

        req = "R7";
        send_bits({3'd4, 18'h3C3C3}, 0, 6, 1'b0);
        idle(TO * 3);
        send_bits({3'd4, 18'h00F0F}, 0, 20, 1'b1);
        idle(10);
        send_bits({3'd1, 18'h1ABCD}, 0, 9, 1'b0);
        idle(40);
        send_bits({3'd1, 18'h1ABCD}, 10, 20, 1'b1);
        idle(20);

        req = "R5";
        send_bits({3'd7, 18'h3FFFF}, 0, 19, 1'b0);
        idle(TO * 3);
        checks++;
        if (wr_addr !== 3'd1 || wr_data !== 18'h1ABCD) begin
            errors++;
            $display("FAIL R5 hold: got %h %h expected 1 1abcd", wr_addr, wr_data);
        end

        req = "R9";
        send_bits({3'd3, 18'h2AAAA}, 0, 20, 1'b1);
        idle(20);

        done = 1'b1;
        checks++;
        if (exp_cyc.size() != 0) begin
            errors++;
            $display("FAIL R4 pending: got %0d expected 0", exp_cyc.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule